// File: doc/BRIEF.md
# Cyclic Sample-Memory Playback Sequencer

This block walks an address counter through a per-channel sample memory, one address per clock. In playback, each channel can present the stored word at the current address in place of its live input. This lets a known test pattern, for example one non-zero word on a chosen bunch tick and zero elsewhere, be replayed into downstream logic. In capture, the same address sweep writes the live samples of the selected channels into their memories. A two-word register port holds the control bits and the address limit. A preload port fills memory words before a run.

The sweep always starts at address 0 and ends at the programmed limit plus one. Each bunch tick uses four consecutive addresses, so the word for tick N sits at offset 4·(N−1). The counter is started by a rising edge on a trigger bit. It either wraps forever or makes a single pass, and it can be told to halt on an external monitor-save event. The preload port is valid/ready: a word is written on a cycle where both `ld_valid` and `ld_ready` are high, and the source must hold the word stable while `ld_ready` is low. The output stream has no back-pressure, because the sample timing is fixed, so the consumer must take every beat on which `out_valid` is high.

Top module: `sample_playback_seq`

## Requirements
- R1: After reset, both registers read 0, the counter is idle and `out_valid` is low. Every memory word is then cleared to zero by a sweep lasting 2^AW cycles.
- R2: A start happens only when a write to register 0 changes bit 0 from 0 to 1 while the counter is idle, and it always begins at address 0. Writing bit 0 as 1 when it is already 1, or triggering while the counter runs, has no effect.
- R3: While running, the counter issues consecutive addresses 0, 1, … limit+1, one per cycle.
- R4: With bit 1 of register 0 set, the address after limit+1 is 0. With bit 1 clear, the counter goes idle after issuing limit+1.
- R5: With bit 2 of register 0 set, a cycle with `mon_evt` high issues no address and leaves the counter idle. With bit 2 clear, `mon_evt` has no effect.
- R6: With bit 3 of register 0 set, every issued address writes `live_data` of each channel whose `chan_cap` bit is set into that channel's memory at that address. A read of the same address in the same cycle returns the old word.
- R7: One cycle after an address is issued, `out_valid` is high and `out_addr` and `out_phase` (= address bits 1:0) show that address. `out_data` of channel c is its memory word at that address when `chan_sel[c]` is 1, or the `live_data` of the issue cycle when it is 0. Channel c occupies bits c·DW upward.
- R8: `ld_ready` is low during the clear sweep and while the counter runs with bit 3 set, and high otherwise. An accepted preload writes `ld_data` to memory `ld_chan` at `ld_addr`.
- R9: Register 1 holds the limit. Values above 2^AW−2 are stored as 2^AW−2. Register 0 reads back bits 3:0 as written, with the running status at bit 4.
- R10: Words never loaded play back as zero. A word preloaded at offset 36 appears only on the first beat of tick 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 limit |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| ld_valid | input | 1 | Preload word valid |
| ld_ready | output | 1 | Preload port can accept |
| ld_chan | input | $clog2(NCH) | Preload target channel |
| ld_addr | input | AW | Preload target address |
| ld_data | input | DW | Preload word |
| mon_evt | input | 1 | External monitor-save event |
| chan_sel | input | NCH | Per channel: 1 memory playback, 0 live |
| chan_cap | input | NCH | Per channel: follow global capture enable |
| live_data | input | NCH·DW | Live samples, channel c at bits c·DW |
| out_valid | output | 1 | Output beat valid |
| out_addr | output | AW | Address of this beat |
| out_phase | output | 2 | Position inside the bunch tick |
| out_data | output | NCH·DW | Per-channel selected value |

## Verification
A corrupted counter shows up on the next output beat as an `out_addr` that breaks the 0…limit+1 run, or as a missing or extra wrap one cycle after the end of the pass. A wrong memory word, a misrouted capture, or a lost preload appears only when its address is replayed, one cycle after issue, so the checks sweep every written location in later passes. Stuck running state shows in bit 4 of register 0 and in `ld_ready` within one cycle.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;
  localparam int REG_W     = 16;
  localparam int CTRL_TRIG = 0;
  localparam int CTRL_REP  = 1;
  localparam int CTRL_HALT = 2;
  localparam int CTRL_WE   = 3;
endpackage

// File: rtl/sps_regs.sv
`timescale 1ns/1ps
module sps_regs
  import sps_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             running,
  output logic [REG_W-1:0] reg_rdata,
  output logic             start_req,
  output logic             rep_en,
  output logic             halt_en,
  output logic             gwe,
  output logic [AW-1:0]    limit
);
  localparam int DEPTH = 1 << AW;
  localparam logic [REG_W-1:0] LIM_MAX = REG_W'(DEPTH - 2);

  logic [3:0]    ctrl_q;
  logic [AW-1:0] lim_q;
  logic          wr_ctrl, wr_lim;

  assign wr_ctrl = reg_wr && !reg_addr;
  assign wr_lim  = reg_wr && reg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lim_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[3:0];
      if (wr_lim)  lim_q  <= (reg_wdata > LIM_MAX) ? LIM_MAX[AW-1:0] : reg_wdata[AW-1:0];
    end
  end

  // start only on a 0->1 change of the trigger bit
  assign start_req = wr_ctrl && reg_wdata[CTRL_TRIG] && !ctrl_q[CTRL_TRIG];
  assign rep_en    = ctrl_q[CTRL_REP];
  assign halt_en   = ctrl_q[CTRL_HALT];
  assign gwe       = ctrl_q[CTRL_WE];
  assign limit     = lim_q;
  assign reg_rdata = reg_addr ? REG_W'(lim_q) : REG_W'({running, ctrl_q});

  // R9
  limit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    REG_W'(lim_q) <= LIM_MAX);
endmodule

// File: rtl/sps_addr_gen.sv
`timescale 1ns/1ps
module sps_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          ready,
  input  logic          rep_en,
  input  logic          halt_en,
  input  logic          mon_evt,
  input  logic [AW-1:0] limit,
  output logic          running,
  output logic          iss_valid,
  output logic [AW-1:0] iss_addr
);
  logic          run_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] last;
  logic          halt;

  assign last = limit + AW'(1);
  assign halt = halt_en && mon_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else if (run_q) begin
      if (halt) begin
        run_q <= 1'b0;
      end else if (addr_q >= last) begin
        if (rep_en) addr_q <= '0;
        else        run_q  <= 1'b0;
      end else begin
        addr_q <= addr_q + AW'(1);
      end
    end else if (start_req && ready) begin
      run_q  <= 1'b1;
      addr_q <= '0;
    end
  end

  assign running   = run_q;
  assign iss_valid = run_q && !halt;
  assign iss_addr  = addr_q;

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && ready && !run_q) |=> (run_q && addr_q == '0));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !halt && addr_q < last) |=> (run_q && addr_q == $past(addr_q) + AW'(1)));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !halt && addr_q >= last && rep_en) |=> (run_q && addr_q == '0));
  // R4
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !halt && addr_q >= last && !rep_en) |=> !run_q);
  // R5
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && halt) |=> !run_q);
endmodule

// File: rtl/sps_chan_mem.sv
`timescale 1ns/1ps
module sps_chan_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first: a same-cycle write to raddr is seen on the next read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sample_playback_seq.sv
`timescale 1ns/1ps
module sample_playback_seq
  import sps_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CW-1:0]     ld_chan,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DW-1:0]     ld_data,
  input  logic              mon_evt,
  input  logic [NCH-1:0]    chan_sel,
  input  logic [NCH-1:0]    chan_cap,
  input  logic [NCH*DW-1:0] live_data,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_phase,
  output logic [NCH*DW-1:0] out_data
);
  localparam int DEPTH = 1 << AW;

  logic          running, iss_valid, start_req, rep_en, halt_en, gwe;
  logic [AW-1:0] iss_addr, limit;
  logic          clr_busy;
  logic [AW-1:0] clr_addr;
  logic          ld_fire, cap_on;

  sps_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .running(running), .reg_rdata(reg_rdata),
    .start_req(start_req), .rep_en(rep_en), .halt_en(halt_en), .gwe(gwe),
    .limit(limit)
  );

  sps_addr_gen #(.AW(AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ready(!clr_busy),
    .rep_en(rep_en), .halt_en(halt_en), .mon_evt(mon_evt), .limit(limit),
    .running(running), .iss_valid(iss_valid), .iss_addr(iss_addr)
  );

  // zero-fill sweep after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_busy <= 1'b1;
      clr_addr <= '0;
    end else if (clr_busy) begin
      clr_addr <= clr_addr + AW'(1);
      if (clr_addr == AW'(DEPTH - 1)) clr_busy <= 1'b0;
    end
  end

  assign ld_ready = !clr_busy && !(running && gwe);
  assign ld_fire  = ld_valid && ld_ready;
  assign cap_on   = iss_valid && gwe;

  logic [DW-1:0]     rd [NCH];
  logic              s1_valid;
  logic [AW-1:0]     s1_addr;
  logic [NCH-1:0]    s1_sel;
  logic [NCH*DW-1:0] s1_live;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;

    always_comb begin
      if (clr_busy) begin
        we = 1'b1; wa = clr_addr; wd = '0;
      end else if (cap_on && chan_cap[ch]) begin
        we = 1'b1; wa = iss_addr; wd = live_data[ch*DW +: DW];
      end else begin
        we = ld_fire && (ld_chan == CW'(ch)); wa = ld_addr; wd = ld_data;
      end
    end

    sps_chan_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .we(we), .waddr(wa), .wdata(wd), .raddr(iss_addr), .rdata(rd[ch])
    );

    assign out_data[ch*DW +: DW] = s1_sel[ch] ? rd[ch] : s1_live[ch*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_sel   <= '0;
      s1_live  <= '0;
    end else begin
      s1_valid <= iss_valid;
      s1_addr  <= iss_addr;
      s1_sel   <= chan_sel;
      s1_live  <= live_data;
    end
  end

  assign out_valid = s1_valid;
  assign out_addr  = s1_addr;
  assign out_phase = s1_addr[1:0];

  // R8
  ld_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |-> !(cap_on || clr_busy));
  // R7
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> (out_valid && out_addr == $past(iss_addr)));
  // R1
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !running);
endmodule

// File: tb/sample_playback_seq_tb.sv
`timescale 1ns/1ps
module sample_playback_seq_tb;
  localparam int NCH = 4;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int CW = 2;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic ld_valid = 0, ld_ready;
  logic [CW-1:0] ld_chan = 0;
  logic [AW-1:0] ld_addr = 0;
  logic [DW-1:0] ld_data = 0;
  logic mon_evt = 0;
  logic [NCH-1:0] chan_sel = '1, chan_cap = '0;
  logic [NCH*DW-1:0] live_data = 0;
  logic out_valid;
  logic [AW-1:0] out_addr;
  logic [1:0] out_phase;
  logic [NCH*DW-1:0] out_data;

  sample_playback_seq #(.NCH(NCH), .DW(DW), .AW(AW)) u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mdl [NCH][DEPTH];
  int lim_v = 0, mon_next = 0, beats = 0, nz0 = 0;
  bit we_v = 0;
  logic [NCH*DW-1:0] live_last = 0;
  int unsigned seed_dummy;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int next_addr(int a, int lim);
    return (a >= lim + 1) ? 0 : a + 1;
  endfunction

  // output monitor: model of R3, R6, R7
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk(out_addr == AW'(mon_next), "R3", "out_addr", out_addr, mon_next);
      chk(out_phase == out_addr[1:0], "R7", "out_phase", out_phase, out_addr[1:0]);
      for (int ch = 0; ch < NCH; ch++) begin
        logic [DW-1:0] e;
        e = chan_sel[ch] ? mdl[ch][out_addr] : live_last[ch*DW +: DW];
        chk(out_data[ch*DW +: DW] == e, "R7 R6", "out_data", out_data[ch*DW +: DW], e);
      end
      if (we_v)
        for (int ch = 0; ch < NCH; ch++)
          if (chan_cap[ch]) mdl[ch][out_addr] = live_last[ch*DW +: DW];
      if (chan_sel[0] && out_data[DW-1:0] != 0) nz0++;
      beats++;
      mon_next = next_addr(out_addr, lim_v);
    end
    live_data = {$urandom, $urandom};
    live_last = live_data;
  end

  task automatic reg_write(bit a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(bit a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 2000; i++) begin
      reg_read(0, d);
      if (!d[4]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic preload(int ch, int a, logic [DW-1:0] d);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1; ld_chan = CW'(ch); ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_valid = 0;
    mdl[ch][a] = d;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic start_run(int lim, bit rep, bit halt, bit we);
    logic [3:0] c;
    reg_write(1, 16'(lim));
    lim_v = lim; we_v = we; mon_next = 0; beats = 0;
    c = {we, halt, rep, 1'b0};
    reg_write(0, {12'd0, c});
    reg_write(0, {12'd0, c | 4'b0001});
    reg_write(0, {12'd0, c});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    seed_dummy = $urandom(32'h5A17);
    for (int ch = 0; ch < NCH; ch++)
      for (int a = 0; a < DEPTH; a++) mdl[ch][a] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    reg_read(0, d); chk(d == 0, "R1", "ctrl after reset", d, 0);
    reg_read(1, d); chk(d == 0, "R1", "limit after reset", d, 0);
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(!ld_ready, "R8", "ld_ready during clear", ld_ready, 0);
    n = 0;
    while (!ld_ready && n < DEPTH + 10) begin @(negedge clk); n++; end
    chk(ld_ready, "R8", "ld_ready after clear", ld_ready, 1);

    // R1 R10: zero playback, one pass
    chan_sel = '1;
    start_run(10, 0, 0, 0);
    wait_idle();
    chk(beats == 12, "R3", "beats limit 10", beats, 12);
    reg_read(0, d); chk(d[4] == 0, "R4", "idle after single pass", d[4], 0);
    chk(nz0 == 0, "R10", "nonzero beats after clear", nz0, 0);

    // R2: trigger bit held high does not restart
    reg_write(0, 16'h0001);
    wait_idle();
    chk(beats == 24, "R2", "start from cleared trigger", beats, 24);
    reg_write(0, 16'h0001);
    repeat (3) @(negedge clk);
    reg_read(0, d); chk(d[4] == 0, "R2", "held trigger no restart", d[4], 0);
    reg_write(0, 16'h0000);

    // R10: tick 10 word at offset 36
    preload(0, 36, 8'hFF);
    preload(1, 36, 8'hFF);
    nz0 = 0;
    start_run(62, 0, 0, 0);
    wait_idle();
    chk(nz0 == 1, "R10", "tick 10 nonzero count", nz0, 1);
    chk(beats == 64, "R3", "beats limit 62", beats, 64);

    // random preloads and mixed selection
    for (int it = 0; it < 3; it++) begin
      int lim;
      for (int k = 0; k < 30; k++)
        preload($urandom % NCH, $urandom % DEPTH, 8'($urandom));
      chan_sel = NCH'($urandom);
      lim = 5 + ($urandom % 200);
      start_run(lim, 0, 0, 0);
      wait_idle();
      chk(beats == lim + 2, "R3", "beats random pass", beats, lim + 2);
    end

    // R4 repeat plus R2 retrigger during run
    chan_sel = '1;
    start_run(20, 1, 0, 0);
    repeat (50) @(negedge clk);
    reg_write(0, 16'h0003);
    reg_write(0, 16'h0002);
    repeat (40) @(negedge clk);
    reg_read(0, d); chk(d[4] == 1, "R4", "still running in repeat", d[4], 1);
    reg_write(0, 16'h0000);
    wait_idle();
    chk(mon_next == 0, "R4", "pass finished at last address", mon_next, 0);
    chk(beats > 66, "R4", "wrapped beats", beats, 67);

    // R5 event ignored, then halts
    start_run(30, 1, 0, 0);
    repeat (8) @(negedge clk);
    mon_evt = 1; @(negedge clk); mon_evt = 0;
    repeat (4) @(negedge clk);
    reg_read(0, d); chk(d[4] == 1, "R5", "event ignored when disabled", d[4], 1);
    reg_write(0, 16'h0006);
    repeat (5) @(negedge clk);
    mon_evt = 1; @(negedge clk); mon_evt = 0;
    @(negedge clk);
    chk(!out_valid, "R5", "no beat after halt", out_valid, 0);
    reg_read(0, d); chk(d[4] == 0, "R5", "halted", d[4], 0);
    reg_write(0, 16'h0000);

    // R6 capture then playback
    chan_sel = 4'b0010; chan_cap = 4'b0110;
    start_run(40, 0, 0, 1);
    @(negedge clk);
    chk(!ld_ready, "R8", "ld_ready low during capture", ld_ready, 0);
    wait_idle();
    chk(ld_ready, "R8", "ld_ready back after capture", ld_ready, 1);
    reg_write(0, 16'h0000);
    chan_cap = '0; chan_sel = '1;
    start_run(40, 0, 0, 0);
    wait_idle();
    chk(beats == 42, "R6", "playback of captured words", beats, 42);

    // R9 limit saturation and boundaries
    reg_write(1, 16'hFFFF);
    reg_read(1, d); chk(d == DEPTH - 2, "R9", "limit saturates", d, DEPTH - 2);
    reg_write(0, 16'h000A);
    reg_read(0, d); chk(d == 16'h000A, "R9", "ctrl readback", d, 16'h000A);
    reg_write(0, 16'h0000);
    start_run(0, 0, 0, 0);
    wait_idle();
    chk(beats == 2, "R3", "limit 0 beats", beats, 2);
    start_run(DEPTH - 2, 0, 0, 0);
    wait_idle();
    chk(beats == DEPTH, "R3", "full depth beats", beats, DEPTH);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule